// File: doc/BRIEF.md
# Sparkle-tolerant thermometer to binary encoder

This block takes the 2^B−1 comparator outputs of a B-bit flash converter and returns the B-bit binary code of the input level. In an ideal thermometer word every comparator below the input level reads 1 and every comparator above it reads 0. The raw comparator bits first pass through two register stages. These give any comparator that is slow to settle the time to resolve to a clean level before several decode gates sample it.

The resolved word goes to a row decoder. Row k is active when the bit at position k of the word, extended with a constant 1 below the lowest comparator, is 1 and the next two bits above it are both 0. The active rows are then combined by OR into binary, the way a wired-NOR ROM would combine them. Each row only fires below two zeros, so a single 0 dropped inside the run of ones cannot select a second row. A single stray 1 one place above the run also selects only one row. The datapath is pipelined and accepts a new word on every clock.

Top module: `thermo_sparkle_enc`

## Requirements
- R1: An all-zero comparator word gives code 0.
- R2: An all-one comparator word gives code 2^B−1.
- R3: A clean thermometer word with its lowest L bits set (bits 0 to L−1) gives code L, and exactly one row is active.
- R4: A word with its lowest L bits set, except for one bit at position p < L−1 that is cleared, still gives code L. At least one row is always active.
- R5: A word with its lowest L bits set plus one isolated set bit at position L+1 (bit L clear) gives code L+2 from a single row, not the OR of two rows.
- R6: A comparator word sampled at a rising clock edge appears on code_out after the third rising edge, counting that edge as the first. A new word is accepted on every clock.
- R7: While rst_n is low, code_out is 0, whatever the comparator inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_in | input | 2^B−1 | Comparator outputs; bit i is the i-th level from the bottom |
| code_out | output | B | Registered binary code |

## Verification
On every cycle, the assertions check three things. At least one row is always active. A clean thermometer word selects exactly one row. The output equals the count of ones in the clean word sampled three edges earlier. Only the bench's scenarios can show the following: handling of a dropped bit inside the ones, where the output equals the top of the run; the two-LSB result of a stray 1 just above the run; the cycle-exact streaming of back-to-back words; and the reset value.

// File: rtl/thermo_sparkle_enc.sv
module thermo_sparkle_enc #(
  parameter int B = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [(2**B)-2:0]   comp_in,
  output logic [B-1:0]        code_out
);
  localparam int N    = (2**B) - 1;
  localparam int ROWS = N + 1;

  logic [N-1:0]    stage_a, stage_b;
  logic [N+2:0]    ext;
  logic [ROWS-1:0] row;
  logic [B-1:0]    rom;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_a <= '0;
      stage_b <= '0;
    end else begin
      stage_a <= comp_in;
      stage_b <= stage_a;
    end
  end

  assign ext = {2'b00, stage_b, 1'b1};

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    assign row[k] = ext[k] & ~ext[k+1] & ~ext[k+2];
  end

  always_comb begin
    rom = '0;
    for (int k = 0; k < ROWS; k++)
      if (row[k]) rom = rom | B'(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_out <= '0;
    else        code_out <= rom;
  end

  logic [1:0] fill;
  logic       clean_b;
  logic       clean_in;
  assign clean_b  = ((stage_b & (stage_b + N'(1))) == '0);
  assign clean_in = ((comp_in & (comp_in + N'(1))) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fill <= '0;
    else if (fill != 2'd3) fill <= fill + 2'd1;
  end

  // R3
  single_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clean_b |-> $onehot(row));

  // R4
  row_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row != '0);

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == 2'd3 && $past(clean_in, 3)) |-> code_out == B'($countones($past(comp_in, 3))));

  // R2
  full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == 2'd3 && $past(comp_in, 3) == '1) |-> code_out == B'(N));
endmodule

// File: tb/thermo_sparkle_enc_tb.sv
module thermo_sparkle_enc_tb;
  localparam int B = 4;
  localparam int N = (2**B) - 1;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] comp_in = '0;
  logic [B-1:0] code_out;
  int total = 0;
  int bad = 0;
  bit done = 0;

  thermo_sparkle_enc #(.B(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .comp_in(comp_in), .code_out(code_out));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [N-1:0] therm(int lvl);
    logic [N-1:0] t = '0;
    for (int i = 0; i < N; i++) if (i < lvl) t[i] = 1'b1;
    return t;
  endfunction

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply_and_check(string req, logic [N-1:0] w, int exp);
    @(negedge clk) comp_in = w;
    repeat (3) @(posedge clk);
    @(negedge clk) check(req, int'(code_out), exp);
  endtask

  task automatic t_reset();
    @(negedge clk) comp_in = '1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) check("R7 reset holds zero", int'(code_out), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_ends();
    apply_and_check("R1 all zero", '0, 0);
    apply_and_check("R2 all one", '1, N);
  endtask

  task automatic t_levels();
    for (int l = 0; l <= N; l++) apply_and_check("R3 clean level", therm(l), l);
  endtask

  task automatic t_bubbles();
    logic [N-1:0] w;
    w = therm(10); w[4] = 1'b0;  apply_and_check("R4 bubble mid", w, 10);
    w = therm(5);  w[0] = 1'b0;  apply_and_check("R4 bubble bottom", w, 5);
    w = therm(9);  w[7] = 1'b0;  apply_and_check("R4 bubble below top", w, 9);
    w = '1;        w[13] = 1'b0; apply_and_check("R4 bubble full scale", w, N);
  endtask

  task automatic t_near_sparkle();
    logic [N-1:0] w;
    w = therm(6); w[7] = 1'b1; apply_and_check("R5 stray one L=6", w, 8);
    w = '0;       w[1] = 1'b1; apply_and_check("R5 stray one L=0", w, 2);
    w = therm(3); w[4] = 1'b1; apply_and_check("R5 stray one L=3", w, 5);
  endtask

  task automatic t_stream();
    int lv [12];
    apply_and_check("R6 baseline", '0, 0);
    for (int k = 0; k < 12; k++) lv[k] = (k * 7 + 3) % (N + 1);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (k >= 3) check("R6 streaming latency", int'(code_out), lv[k-3]);
      else        check("R6 not early", int'(code_out), 0);
      if (k < 12) comp_in = therm(lv[k]);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) check("R7 reset value", int'(code_out), 0);
    rst_n = 1'b1;
    t_ends();
    t_levels();
    t_bubbles();
    t_near_sparkle();
    t_stream();
    t_reset();
    apply_and_check("R3 after reset", therm(7), 7);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule